// File: doc/BRIEF.md
# AXI-Lite Data Width Up-Converter

This block joins a narrow AXI-Lite master to a wider AXI-Lite slave. Each narrow write or read is carried across as exactly one wide transaction. The wide address is the narrow address with its sub-word offset cleared. The write data and strobe travel in the byte lanes picked by the offset, and a read returns to the master only the lanes picked by its offset. The ratio of wide to narrow width is a power of two, at least two. Several narrow accesses are never folded into one wide access, even when they hit the same wide word.

The write and read paths are two independent state machines, and each holds one transaction at a time. The write machine runs `WR_IDLE` -> `WR_FWD` (accept: narrow address and data both valid) -> `WR_WAIT_B` (forwarded: wide address and data both handshaken) -> `WR_REPLY` (wide response taken) -> `WR_IDLE` (narrow response handshaken). The read machine runs `RD_IDLE` -> `RD_FWD` (narrow address accepted) -> `RD_WAIT_R` (wide address handshaken) -> `RD_REPLY` (wide data taken, lane selected) -> `RD_IDLE` (narrow data handshaken).

Top module: `axil_upsizer`

## Requirements
- R1: The wide address of every forwarded write and read equals the narrow address with its low log2(WIDE_W/8) bits set to zero (8-to-32: 0x7 becomes 0x4, 0x102 becomes 0x100).
- R2: Forwarded write data carries the narrow data in lane L = (address mod WIDE_W/8) div (NARROW_W/8), which covers bits [L*NARROW_W +: NARROW_W]. All other wide data bits are zero (8-to-32: 0x5A at address 0x3 becomes 0x5A000000).
- R3: The forwarded write strobe is the narrow strobe shifted left by L*NARROW_W/8 bits, with all other strobe bits zero (8-to-32: strobe 1 at address 0x3 becomes 0b1000, and strobe 0 stays all zero).
- R4: Each narrow write produces exactly one wide write, including back-to-back writes to the same wide word.
- R5: Each narrow read produces exactly one wide read. The returned narrow data is bits [L*NARROW_W +: NARROW_W] of the wide read data, with L taken from the narrow address held since acceptance, even if the master changes its address afterwards.
- R6: The 2-bit write and read response codes of the wide slave are returned unchanged on the narrow port (0 to 3 all pass through).
- R7: A wide address or data valid, once raised, stays high with a stable payload until its handshake.
- R8: A narrow response valid stays high with stable payload until the master takes it. No new narrow address is accepted on a path while a transaction on that path is in flight.
- R9: After reset, no valid is driven on either port, the read path is ready for an address, and the write path is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Narrow write address valid |
| s_awready | output | 1 | Narrow write address ready |
| s_awaddr | input | ADDR_W | Narrow write byte address |
| s_wvalid | input | 1 | Narrow write data valid |
| s_wready | output | 1 | Narrow write data ready |
| s_wdata | input | NARROW_W | Narrow write data |
| s_wstrb | input | NARROW_W/8 | Narrow write strobe |
| s_bvalid | output | 1 | Narrow write response valid |
| s_bready | input | 1 | Narrow write response ready |
| s_bresp | output | 2 | Narrow write response code |
| s_arvalid | input | 1 | Narrow read address valid |
| s_arready | output | 1 | Narrow read address ready |
| s_araddr | input | ADDR_W | Narrow read byte address |
| s_rvalid | output | 1 | Narrow read data valid |
| s_rready | input | 1 | Narrow read data ready |
| s_rdata | output | NARROW_W | Narrow read data |
| s_rresp | output | 2 | Narrow read response code |
| m_awvalid | output | 1 | Wide write address valid |
| m_awready | input | 1 | Wide write address ready |
| m_awaddr | output | ADDR_W | Wide aligned write address |
| m_wvalid | output | 1 | Wide write data valid |
| m_wready | input | 1 | Wide write data ready |
| m_wdata | output | WIDE_W | Wide lane-steered write data |
| m_wstrb | output | WIDE_W/8 | Wide lane-steered write strobe |
| m_bvalid | input | 1 | Wide write response valid |
| m_bready | output | 1 | Wide write response ready |
| m_bresp | input | 2 | Wide write response code |
| m_arvalid | output | 1 | Wide read address valid |
| m_arready | input | 1 | Wide read address ready |
| m_araddr | output | ADDR_W | Wide aligned read address |
| m_rvalid | input | 1 | Wide read data valid |
| m_rready | output | 1 | Wide read data ready |
| m_rdata | input | WIDE_W | Wide read data |
| m_rresp | input | 2 | Wide read response code |

## Verification
A lane index held in the wrong state shows up within one transaction as data or strobe landing in the wrong lane of the wide word, or as the wrong narrow slice coming back on a read. The lane comparison catches this on the very access that went wrong. A state machine that skips or repeats a state shows as a missing or doubled wide handshake, or as a narrow response that drops before it is taken. The wide-access counters detect this by the end of the same narrow transaction. The sweep visits every lane with both strobe values and every response code, so a fault in any lane or code is seen within the first few dozen accesses.

// File: rtl/upsz_pkg.sv
package upsz_pkg;

    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,
        WR_FWD    = 2'd1,
        WR_WAIT_B = 2'd2,
        WR_REPLY  = 2'd3
    } wr_state_t;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_FWD    = 2'd1,
        RD_WAIT_R = 2'd2,
        RD_REPLY  = 2'd3
    } rd_state_t;

endpackage

// File: rtl/upsz_lane_steer.sv
module upsz_lane_steer #(
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 32
) (
    input  logic [$clog2(WIDE_W/NARROW_W)-1:0] wr_lane,
    input  logic [NARROW_W-1:0]                n_wdata,
    input  logic [NARROW_W/8-1:0]              n_wstrb,
    output logic [WIDE_W-1:0]                  w_wdata,
    output logic [WIDE_W/8-1:0]                w_wstrb,
    input  logic [$clog2(WIDE_W/NARROW_W)-1:0] rd_lane,
    input  logic [WIDE_W-1:0]                  w_rdata,
    output logic [NARROW_W-1:0]                n_rdata
);
    localparam int RATIO  = WIDE_W / NARROW_W;
    localparam int LANE_W = $clog2(RATIO);
    localparam int NB     = NARROW_W / 8;

    logic [NARROW_W-1:0] rd_words [RATIO];

    // One slice per lane: write side zero-fills unselected lanes,
    // read side exposes each lane for the selector below.
    for (genvar l = 0; l < RATIO; l++) begin : g_lane
        assign w_wdata[l*NARROW_W +: NARROW_W] = (wr_lane == LANE_W'(l)) ? n_wdata : '0;
        assign w_wstrb[l*NB +: NB]             = (wr_lane == LANE_W'(l)) ? n_wstrb : '0;
        assign rd_words[l]                     = w_rdata[l*NARROW_W +: NARROW_W];
    end

    assign n_rdata = rd_words[rd_lane];

endmodule

// File: rtl/upsz_wr_fsm.sv
module upsz_wr_fsm
    import upsz_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               s_awvalid,
    output logic                               s_awready,
    input  logic [ADDR_W-1:0]                  s_awaddr,
    input  logic                               s_wvalid,
    output logic                               s_wready,
    input  logic [NARROW_W-1:0]                s_wdata,
    input  logic [NARROW_W/8-1:0]              s_wstrb,
    output logic                               s_bvalid,
    input  logic                               s_bready,
    output logic [1:0]                         s_bresp,
    output logic                               m_awvalid,
    input  logic                               m_awready,
    output logic [ADDR_W-1:0]                  m_awaddr,
    output logic                               m_wvalid,
    input  logic                               m_wready,
    input  logic                               m_bvalid,
    output logic                               m_bready,
    input  logic [1:0]                         m_bresp,
    input  logic [WIDE_W/8-1:0]                m_wstrb_mon,
    output logic [$clog2(WIDE_W/NARROW_W)-1:0] hold_lane,
    output logic [NARROW_W-1:0]                hold_data,
    output logic [NARROW_W/8-1:0]              hold_strb
);
    localparam int RATIO    = WIDE_W / NARROW_W;
    localparam int LANE_W   = $clog2(RATIO);
    localparam int WBYTES   = WIDE_W / 8;
    localparam int NBYTES   = NARROW_W / 8;
    localparam int OFS_W    = $clog2(WBYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << OFS_W;

    wr_state_t state_q, state_d;
    logic      aw_done_q, w_done_q;
    logic      accept, aw_hs, w_hs;

    assign accept = (state_q == WR_IDLE) && s_awvalid && s_wvalid;
    assign aw_hs  = m_awvalid && m_awready;
    assign w_hs   = m_wvalid && m_wready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE:   if (accept) state_d = WR_FWD;
            WR_FWD:    if ((aw_done_q || aw_hs) && (w_done_q || w_hs)) state_d = WR_WAIT_B;
            WR_WAIT_B: if (m_bvalid) state_d = WR_REPLY;
            WR_REPLY:  if (s_bready) state_d = WR_IDLE;
            default:   state_d = WR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        s_awready = 1'b0;
        s_wready  = 1'b0;
        m_awvalid = 1'b0;
        m_wvalid  = 1'b0;
        m_bready  = 1'b0;
        s_bvalid  = 1'b0;
        unique case (state_q)
            WR_IDLE: begin
                s_awready = s_awvalid && s_wvalid;
                s_wready  = s_awvalid && s_wvalid;
            end
            WR_FWD: begin
                m_awvalid = !aw_done_q;
                m_wvalid  = !w_done_q;
            end
            WR_WAIT_B: m_bready = 1'b1;
            WR_REPLY:  s_bvalid = 1'b1;
            default: ;
        endcase
    end

    // held payload and sub-handshake flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_awaddr  <= '0;
            hold_lane <= '0;
            hold_data <= '0;
            hold_strb <= '0;
            aw_done_q <= 1'b0;
            w_done_q  <= 1'b0;
            s_bresp   <= 2'b00;
        end else begin
            if (accept) begin
                m_awaddr  <= s_awaddr & ALIGN_MASK;
                hold_lane <= s_awaddr[OFS_W-1 -: LANE_W];
                hold_data <= s_wdata;
                hold_strb <= s_wstrb;
                aw_done_q <= 1'b0;
                w_done_q  <= 1'b0;
            end else begin
                if (aw_hs) aw_done_q <= 1'b1;
                if (w_hs)  w_done_q  <= 1'b1;
            end
            if (state_q == WR_WAIT_B && m_bvalid) s_bresp <= m_bresp;
        end
    end

    // R7
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));
    // R7
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wstrb_mon)));
    // R8
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));
    // R4
    aw_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aw_hs |=> !m_awvalid);
    // R3
    strb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid |-> ($countones(m_wstrb_mon) <= NBYTES));
    // R1
    aw_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (m_awaddr[OFS_W-1:0] == '0));
    // R8
    aw_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid || m_awvalid || m_wvalid) |-> !s_awready);

endmodule

// File: rtl/upsz_rd_fsm.sv
module upsz_rd_fsm
    import upsz_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               s_arvalid,
    output logic                               s_arready,
    input  logic [ADDR_W-1:0]                  s_araddr,
    output logic                               s_rvalid,
    input  logic                               s_rready,
    output logic [NARROW_W-1:0]                s_rdata,
    output logic [1:0]                         s_rresp,
    output logic                               m_arvalid,
    input  logic                               m_arready,
    output logic [ADDR_W-1:0]                  m_araddr,
    input  logic                               m_rvalid,
    output logic                               m_rready,
    input  logic [1:0]                         m_rresp,
    input  logic [NARROW_W-1:0]                lane_rdata,
    output logic [$clog2(WIDE_W/NARROW_W)-1:0] hold_lane
);
    localparam int RATIO  = WIDE_W / NARROW_W;
    localparam int LANE_W = $clog2(RATIO);
    localparam int WBYTES = WIDE_W / 8;
    localparam int OFS_W  = $clog2(WBYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << OFS_W;

    rd_state_t state_q, state_d;
    logic      accept, take;

    assign accept = (state_q == RD_IDLE) && s_arvalid;
    assign take   = (state_q == RD_WAIT_R) && m_rvalid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:   if (s_arvalid) state_d = RD_FWD;
            RD_FWD:    if (m_arready) state_d = RD_WAIT_R;
            RD_WAIT_R: if (m_rvalid)  state_d = RD_REPLY;
            RD_REPLY:  if (s_rready)  state_d = RD_IDLE;
            default:   state_d = RD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        s_arready = 1'b0;
        m_arvalid = 1'b0;
        m_rready  = 1'b0;
        s_rvalid  = 1'b0;
        unique case (state_q)
            RD_IDLE:   s_arready = 1'b1;
            RD_FWD:    m_arvalid = 1'b1;
            RD_WAIT_R: m_rready  = 1'b1;
            RD_REPLY:  s_rvalid  = 1'b1;
            default: ;
        endcase
    end

    // held address, lane and reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_araddr  <= '0;
            hold_lane <= '0;
            s_rdata   <= '0;
            s_rresp   <= 2'b00;
        end else begin
            if (accept) begin
                m_araddr  <= s_araddr & ALIGN_MASK;
                hold_lane <= s_araddr[OFS_W-1 -: LANE_W];
            end
            if (take) begin
                s_rdata <= lane_rdata;
                s_rresp <= m_rresp;
            end
        end
    end

    // R5
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));
    // R5
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid || m_rready) |=> $stable(hold_lane));
    // R1
    ar_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> (m_araddr[OFS_W-1:0] == '0));
    // R8
    r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));
    // R8
    ar_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid || m_rready || s_rvalid) |-> !s_arready);

endmodule

// File: rtl/axil_upsizer.sv
module axil_upsizer #(
    parameter int ADDR_W   = 12,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  s_awvalid,
    output logic                  s_awready,
    input  logic [ADDR_W-1:0]     s_awaddr,
    input  logic                  s_wvalid,
    output logic                  s_wready,
    input  logic [NARROW_W-1:0]   s_wdata,
    input  logic [NARROW_W/8-1:0] s_wstrb,
    output logic                  s_bvalid,
    input  logic                  s_bready,
    output logic [1:0]            s_bresp,
    input  logic                  s_arvalid,
    output logic                  s_arready,
    input  logic [ADDR_W-1:0]     s_araddr,
    output logic                  s_rvalid,
    input  logic                  s_rready,
    output logic [NARROW_W-1:0]   s_rdata,
    output logic [1:0]            s_rresp,
    output logic                  m_awvalid,
    input  logic                  m_awready,
    output logic [ADDR_W-1:0]     m_awaddr,
    output logic                  m_wvalid,
    input  logic                  m_wready,
    output logic [WIDE_W-1:0]     m_wdata,
    output logic [WIDE_W/8-1:0]   m_wstrb,
    input  logic                  m_bvalid,
    output logic                  m_bready,
    input  logic [1:0]            m_bresp,
    output logic                  m_arvalid,
    input  logic                  m_arready,
    output logic [ADDR_W-1:0]     m_araddr,
    input  logic                  m_rvalid,
    output logic                  m_rready,
    input  logic [WIDE_W-1:0]     m_rdata,
    input  logic [1:0]            m_rresp
);
    localparam int RATIO  = WIDE_W / NARROW_W;
    localparam int LANE_W = $clog2(RATIO);

    initial begin
        assert (RATIO >= 2 && (RATIO & (RATIO - 1)) == 0 && NARROW_W % 8 == 0)
            else $error("width ratio must be a power of two of at least 2");
    end

    logic [LANE_W-1:0]     wr_lane, rd_lane;
    logic [NARROW_W-1:0]   wr_data_q, lane_rdata;
    logic [NARROW_W/8-1:0] wr_strb_q;

    upsz_wr_fsm #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) wr_i (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .m_wstrb_mon(m_wstrb),
        .hold_lane(wr_lane), .hold_data(wr_data_q), .hold_strb(wr_strb_q)
    );

    upsz_rd_fsm #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) rd_i (
        .clk(clk), .rst_n(rst_n),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rresp(m_rresp),
        .lane_rdata(lane_rdata), .hold_lane(rd_lane)
    );

    upsz_lane_steer #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) steer_i (
        .wr_lane(wr_lane), .n_wdata(wr_data_q), .n_wstrb(wr_strb_q),
        .w_wdata(m_wdata), .w_wstrb(m_wstrb),
        .rd_lane(rd_lane), .w_rdata(m_rdata), .n_rdata(lane_rdata)
    );

endmodule

// File: tb/axil_upsizer_tb_top.sv
module axil_upsizer_tb_top;
    localparam int AW = 12;
    localparam int NW = 8;
    localparam int WW = 32;
    localparam int NB = NW / 8;
    localparam int WB = WW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
    logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
    logic [NW-1:0] s_wdata = '0;
    logic [NB-1:0] s_wstrb = '0;
    logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0] s_bresp, s_rresp;
    logic [NW-1:0] s_rdata;
    logic m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
    logic [AW-1:0] m_awaddr, m_araddr;
    logic [WW-1:0] m_wdata;
    logic [WB-1:0] m_wstrb;
    logic m_awready, m_wready, m_bvalid, m_arready, m_rvalid;
    logic [1:0] m_bresp, m_rresp;
    logic [WW-1:0] m_rdata;

    axil_upsizer #(.ADDR_W(AW), .NARROW_W(NW), .WIDE_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // wide read word as a pure function of the aligned address
    function automatic logic [WW-1:0] rword(input logic [AW-1:0] a);
        logic [WW-1:0] w;
        for (int b = 0; b < WB; b++) w[b*8 +: 8] = a[7:0] * 8'd13 + 8'(b) * 8'd29 + 8'h5A;
        return w;
    endfunction

    // wide slave model with pseudo-random stalls
    logic [7:0] lfsr;
    logic [1:0] cfg_bresp = 2'b00, cfg_rresp = 2'b00;
    logic aw_got, w_got, ar_got;
    logic [AW-1:0] log_awaddr, log_araddr;
    logic [WW-1:0] log_wdata;
    logic [WB-1:0] log_wstrb;
    int wr_count, rd_count, stab_err;
    logic aw_wait, ar_wait;
    logic [AW-1:0] aw_seen, ar_seen;

    always @(posedge clk) begin
        if (!rst_n) begin
            lfsr <= 8'hA7; aw_got <= 0; w_got <= 0; ar_got <= 0;
            m_awready <= 0; m_wready <= 0; m_arready <= 0;
            m_bvalid <= 0; m_rvalid <= 0; m_bresp <= 0; m_rresp <= 0; m_rdata <= '0;
            log_awaddr <= '0; log_araddr <= '0; log_wdata <= '0; log_wstrb <= '0;
            wr_count <= 0; rd_count <= 0; stab_err <= 0;
            aw_wait <= 0; ar_wait <= 0; aw_seen <= '0; ar_seen <= '0;
        end else begin
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            // stability watch on the wide address channels
            if (aw_wait && (!m_awvalid || m_awaddr != aw_seen)) stab_err <= stab_err + 1;
            if (ar_wait && (!m_arvalid || m_araddr != ar_seen)) stab_err <= stab_err + 1;
            aw_wait <= m_awvalid && !m_awready; aw_seen <= m_awaddr;
            ar_wait <= m_arvalid && !m_arready; ar_seen <= m_araddr;

            if (m_awvalid && m_awready) begin
                aw_got <= 1; log_awaddr <= m_awaddr; wr_count <= wr_count + 1;
            end
            if (m_wvalid && m_wready) begin
                w_got <= 1; log_wdata <= m_wdata; log_wstrb <= m_wstrb;
            end
            m_awready <= lfsr[0] && !aw_got && !(m_awvalid && m_awready);
            m_wready  <= lfsr[1] && !w_got && !(m_wvalid && m_wready);
            if (aw_got && w_got && !m_bvalid) begin
                m_bvalid <= 1; m_bresp <= cfg_bresp;
            end
            if (m_bvalid && m_bready) begin
                m_bvalid <= 0; aw_got <= 0; w_got <= 0;
            end

            if (m_arvalid && m_arready) begin
                ar_got <= 1; log_araddr <= m_araddr; rd_count <= rd_count + 1;
            end
            m_arready <= lfsr[2] && !ar_got && !(m_arvalid && m_arready);
            if (ar_got && !m_rvalid) begin
                m_rvalid <= 1; m_rresp <= cfg_rresp; m_rdata <= rword(log_araddr);
            end
            if (m_rvalid && m_rready) begin
                m_rvalid <= 0; ar_got <= 0;
            end
        end
    end

    function automatic int lane_of(input logic [AW-1:0] a);
        return (int'(a) % WB) / NB;
    endfunction

    task automatic nwrite(input logic [AW-1:0] a, input logic [NW-1:0] d,
                          input logic [NB-1:0] s, input logic [1:0] br);
        int wc0;
        logic [AW-1:0] al;
        logic [WW-1:0] exp_d;
        logic [WB-1:0] exp_s;
        cfg_bresp = br;
        wc0 = wr_count;
        al = a & ~AW'(WB - 1);
        exp_d = WW'(d) << (lane_of(a) * NW);
        exp_s = WB'(s) << (lane_of(a) * NB);
        @(posedge clk); #1;
        s_awvalid = 1; s_wvalid = 1; s_awaddr = a; s_wdata = d; s_wstrb = s;
        do @(negedge clk); while (!s_awready);
        @(posedge clk); #1;
        s_awvalid = 0; s_wvalid = 0; s_awaddr = ~a; s_wdata = ~d; s_wstrb = ~s;
        do @(negedge clk); while (!s_bvalid);
        check("R8 narrow write address refused while busy", 64'(s_awready), 64'(0));
        repeat (2) @(negedge clk);
        check("R8 write response held", 64'(s_bvalid), 64'(1));
        check("R6 write response code", 64'(s_bresp), 64'(br));
        check("R1 wide write address", 64'(log_awaddr), 64'(al));
        check("R2 wide write data", 64'(log_wdata), 64'(exp_d));
        check("R3 wide write strobe", 64'(log_wstrb), 64'(exp_s));
        check("R4 one wide write", 64'(wr_count - wc0), 64'(1));
        s_bready = 1;
        @(posedge clk); #1;
        s_bready = 0;
    endtask

    task automatic nread(input logic [AW-1:0] a, input logic [1:0] rr);
        int rc0;
        logic [AW-1:0] al;
        logic [WW-1:0] w;
        cfg_rresp = rr;
        rc0 = rd_count;
        al = a & ~AW'(WB - 1);
        w = rword(al) >> (lane_of(a) * NW);
        @(posedge clk); #1;
        s_arvalid = 1; s_araddr = a;
        do @(negedge clk); while (!s_arready);
        @(posedge clk); #1;
        s_arvalid = 0; s_araddr = a ^ AW'(WB - 1);
        do @(negedge clk); while (!s_rvalid);
        repeat (2) @(negedge clk);
        check("R8 read data held", 64'(s_rvalid), 64'(1));
        check("R1 wide read address", 64'(log_araddr), 64'(al));
        check("R5 narrow read lane data", 64'(s_rdata), 64'(w[NW-1:0]));
        check("R5 one wide read", 64'(rd_count - rc0), 64'(1));
        check("R6 read response code", 64'(s_rresp), 64'(rr));
        s_rready = 1;
        @(posedge clk); #1;
        s_rready = 0;
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 s_bvalid after reset", 64'(s_bvalid), 64'(0));
        check("R9 s_rvalid after reset", 64'(s_rvalid), 64'(0));
        check("R9 m_awvalid after reset", 64'(m_awvalid), 64'(0));
        check("R9 m_wvalid after reset", 64'(m_wvalid), 64'(0));
        check("R9 m_arvalid after reset", 64'(m_arvalid), 64'(0));
        check("R9 s_arready after reset", 64'(s_arready), 64'(1));
        check("R9 s_awready after reset", 64'(s_awready), 64'(0));
        @(posedge clk); #1;
        rst_n = 1;

        // sweep every byte offset of four wide words, both strobe values,
        // every response code
        for (int a = 0; a < 16; a++) begin
            for (int s = 0; s < 2; s++) begin
                nwrite(AW'(a + 12'h100), NW'(a * 37 + s * 91 + 5), NB'(s), 2'((a + s) % 4));
            end
        end
        // R4 back-to-back writes inside one wide word, each one forwarded
        for (int a = 4; a < 8; a++) nwrite(AW'(a), NW'(8'hC0 + a), NB'(1), 2'b00);
        check("R4 total wide writes equal narrow writes", 64'(wr_count), 64'(36));

        // read sweep; R5 lane comes from the held address
        for (int a = 0; a < 16; a++) nread(AW'(a + 12'h2F0), 2'(a % 4));
        for (int a = 0; a < 4; a++) nread(AW'(12'h7), 2'(a));
        check("R5 total wide reads equal narrow reads", 64'(rd_count), 64'(20));
        check("R7 wide address stable until handshake", 64'(stab_err), 64'(0));
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=completion", cyc);
        end
        #5;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule